// File: doc/BRIEF.md
# Static Memory Bus Cycle Generator

This block turns single requests from an internal requester into complete bus cycles on an external asynchronous static memory. The memory has a 16-bit data bus and two active-low byte lane strobes. A request carries a direction, an address, two byte enables and write data. The block holds the request while it drives chip select, output enable, write enable and the lane strobes with programmable timing. It acknowledges the request with a one-clock pulse and, for reads, presents the captured data.

Three configuration bits and four wait counts arrive as register-held inputs. They are sampled only when a request is accepted, so a bus cycle that is already running keeps its timing:

- The first bit chooses how the lane strobes behave on reads. They either stay high, so byte-wide parts that use them as write enables are not written, or they go low, so a 16-bit part drives both halves of the bus.
- The second bit replaces the separate read and write lengths with one extended length.
- The third bit blocks writes. A blocked write is still acknowledged, and it raises a sticky error flag.

Top module: `sram_cycle_gen`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n, mem_we_n and both bits of mem_bls_n are high, while req_ack, mem_dq_oe and prot_err are low.
- R2: A request is accepted on a clock edge where the block is idle and req_valid is high. On a read of length L, mem_cs_n and mem_oe_n are low for exactly L+1 clocks, starting in the clock after acceptance. mem_we_n stays high throughout. req_ack is high for exactly one clock, the clock right after mem_cs_n returns high.
- R3: rsp_rdata equals the value of mem_dq_i during the last clock in which mem_oe_n is low. It is valid from the acknowledge clock and held until the next read completes.
- R4: When rd_strobe_low is 0, both bits of mem_bls_n stay high during every clock of a read.
- R5: When rd_strobe_low is 1, both bits of mem_bls_n are low during every clock of a read in which mem_cs_n is low.
- R6: Take a write with write-enable delay D and length L, and let W = max(L, D). Count clocks from k=0, the first clock with mem_cs_n low. mem_cs_n is low for k = 0..W+1. mem_we_n is low exactly for k = D..W, so it rises one clock before mem_cs_n. mem_oe_n stays high. req_ack pulses at k = W+2.
- R7: During a write, mem_bls_n[i] is low exactly when mem_we_n is low and req_be[i] is 1. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. This holds whatever the value of rd_strobe_low. mem_dq_oe is high and mem_dq_o equals the write data for every clock with mem_cs_n low.
- R8: When ext_wait_sel is 0, L is wait_rd for reads and wait_wr for writes. When it is 1, L is wait_ext for both.
- R9: A write accepted while wr_protect is 1 never drives mem_cs_n, mem_we_n or mem_bls_n low. It is acknowledged in the clock after acceptance, and prot_err goes high and stays high until reset. Reads are unaffected by wr_protect.
- R10: The configuration bits and wait counts are sampled at the accepting edge. Changing them while a bus cycle runs has no effect on that cycle.
- R11: mem_addr carries the accepted address whenever mem_cs_n is low. mem_dq_oe is never high while mem_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_be | input | 2 | Byte enables (bit 0 = low byte) |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| prot_err | output | 1 | Sticky flag: a write was blocked |
| rd_strobe_low | input | 1 | 1 = lane strobes low on reads |
| ext_wait_sel | input | 1 | 1 = extended length for reads and writes |
| wr_protect | input | 1 | 1 = writes blocked |
| wait_wen | input | CW | Chip-select-to-write-enable delay in clocks |
| wait_rd | input | CW | Read length |
| wait_wr | input | CW | Write length |
| wait_ext | input | CW | Extended length |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | 2 | Byte lane strobes, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
Two activities can land in the same clock: a reprogramming of the configuration bits or wait counts, and a bus cycle that is already running on the previous settings. The bench provokes this by changing every configuration input to fresh random values in the first clock of a cycle. It then judges each pin, clock by clock, against a waveform computed from the values held at acceptance. A second overlap comes from the read data bus, which the bench changes every clock. This forces the capture into the one clock in which output enable is about to rise.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ACK  = 2'd2
    } smc_state_e;

    typedef struct packed {
        logic rd_both_low;
        logic ext_wait;
        logic wr_protect;
    } smc_cfg_t;

endpackage

// File: rtl/smc_snapshot.sv
module smc_snapshot
    import smc_pkg::*;
#(
    parameter int CW = 5,
    localparam int NW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          is_write_i,
    input  smc_cfg_t      cfg_i,
    input  logic [CW-1:0] wen_i,
    input  logic [CW-1:0] rd_i,
    input  logic [CW-1:0] wr_i,
    input  logic [CW-1:0] ext_i,
    output smc_cfg_t      cfg_o,
    output logic [NW-1:0] last_o,
    output logic [NW-1:0] we_first_o,
    output logic [NW-1:0] we_last_o
);

    typedef struct packed {
        smc_cfg_t      cfg;
        logic [NW-1:0] last;
        logic [NW-1:0] first;
        logic [NW-1:0] wlast;
    } snap_t;

    snap_t snap_d, snap_q;
    logic [NW-1:0] len, dly, wlen;

    always_comb begin
        len    = cfg_i.ext_wait ? NW'(ext_i) : (is_write_i ? NW'(wr_i) : NW'(rd_i));
        dly    = NW'(wen_i);
        wlen   = (len >= dly) ? len : dly;
        snap_d = snap_q;
        if (load_i) begin
            snap_d.cfg = cfg_i;
            if (is_write_i) begin
                snap_d.first = dly;
                snap_d.wlast = wlen;
                snap_d.last  = wlen + NW'(1);
            end else begin
                snap_d.first = '0;
                snap_d.wlast = '0;
                snap_d.last  = len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign cfg_o      = snap_q.cfg;
    assign last_o     = snap_q.last;
    assign we_first_o = snap_q.first;
    assign we_last_o  = snap_q.wlast;

endmodule

// File: rtl/smc_cycle_counter.sv
module smc_cycle_counter #(
    parameter int NW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [NW-1:0] cnt_o
);

    logic [NW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run_i ? cnt_q + NW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/smc_strobe_map.sv
module smc_strobe_map (
    input  logic       active_i,
    input  logic       is_write_i,
    input  logic       we_win_i,
    input  logic       rd_both_low_i,
    input  logic [1:0] be_i,
    output logic [1:0] bls_n_o
);

    always_comb begin
        bls_n_o = 2'b11;
        if (active_i) begin
            if (is_write_i) begin
                for (int i = 0; i < 2; i++) begin
                    bls_n_o[i] = !(we_win_i && be_i[i]);
                end
            end else if (rd_both_low_i) begin
                bls_n_o = 2'b00;
            end
        end
    end

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
    import smc_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 5,
    localparam int NW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_be,
    input  logic [15:0]   req_wdata,
    output logic          req_ack,
    output logic [15:0]   rsp_rdata,
    output logic          prot_err,
    input  logic          rd_strobe_low,
    input  logic          ext_wait_sel,
    input  logic          wr_protect,
    input  logic [CW-1:0] wait_wen,
    input  logic [CW-1:0] wait_rd,
    input  logic [CW-1:0] wait_wr,
    input  logic [CW-1:0] wait_ext,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [1:0]    mem_bls_n,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [15:0]   mem_dq_i
);

    typedef struct packed {
        smc_state_e    st;
        logic          wr;
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic [15:0]   wdata;
        logic [15:0]   rdata;
        logic          err;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          load;
    smc_cfg_t      cfg_in, cfg_s;
    logic [NW-1:0] last, we_first, we_last, cnt;
    logic          run, we_win;

    assign cfg_in = '{rd_both_low: rd_strobe_low, ext_wait: ext_wait_sel, wr_protect: wr_protect};

    smc_snapshot #(.CW(CW)) i_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .is_write_i (req_write),
        .cfg_i      (cfg_in),
        .wen_i      (wait_wen),
        .rd_i       (wait_rd),
        .wr_i       (wait_wr),
        .ext_i      (wait_ext),
        .cfg_o      (cfg_s),
        .last_o     (last),
        .we_first_o (we_first),
        .we_last_o  (we_last)
    );

    smc_cycle_counter #(.NW(NW)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .cnt_o (cnt)
    );

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    load        = 1'b1;
                    ctl_d.wr    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.be    = req_be;
                    ctl_d.wdata = req_wdata;
                    if (req_write && wr_protect) begin
                        ctl_d.st  = ST_ACK;
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (cnt == last) begin
                    ctl_d.st = ST_ACK;
                    if (!ctl_q.wr) ctl_d.rdata = mem_dq_i;
                end
            end
            ST_ACK:  ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign run    = (ctl_q.st == ST_RUN);
    assign we_win = run && ctl_q.wr && (cnt >= we_first) && (cnt <= we_last);

    smc_strobe_map i_map (
        .active_i      (run),
        .is_write_i    (ctl_q.wr),
        .we_win_i      (we_win),
        .rd_both_low_i (cfg_s.rd_both_low),
        .be_i          (ctl_q.be),
        .bls_n_o       (mem_bls_n)
    );

    assign mem_cs_n  = !run;
    assign mem_oe_n  = !(run && !ctl_q.wr);
    assign mem_we_n  = !we_win;
    assign mem_dq_oe = run && ctl_q.wr;
    assign mem_dq_o  = ctl_q.wdata;
    assign mem_addr  = ctl_q.addr;
    assign req_ack   = (ctl_q.st == ST_ACK);
    assign rsp_rdata = ctl_q.rdata;
    assign prot_err  = ctl_q.err;

    // R6
    we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    // R6
    we_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> $past(mem_we_n));

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R11
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R9
    prot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> prot_err);

    // R4
    rd_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !cfg_s.rd_both_low) |-> (mem_bls_n == 2'b11));

    // R2
    rd_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

endmodule

// File: tb/test_sram_cycle_gen.sv
module test_sram_cycle_gen;

    localparam int AW = 20;
    localparam int CW = 5;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = '0;
    logic [15:0]   req_wdata = '0;
    logic          req_ack, prot_err;
    logic [15:0]   rsp_rdata;
    logic          rd_strobe_low = 1'b0, ext_wait_sel = 1'b0, wr_protect = 1'b0;
    logic [CW-1:0] wait_wen = '0, wait_rd = '0, wait_wr = '0, wait_ext = '0;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]    mem_bls_n;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_dq_o;
    logic [15:0]   mem_dq_i = '0;

    int  n_run = 0, n_fail = 0;
    bit  exp_err = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_cycle_gen #(.AW(AW), .CW(CW)) i_sram_cycle_gen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .prot_err(prot_err),
        .rd_strobe_low(rd_strobe_low), .ext_wait_sel(ext_wait_sel), .wr_protect(wr_protect),
        .wait_wen(wait_wen), .wait_rd(wait_rd), .wait_wr(wait_wr), .wait_ext(wait_ext),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bls_n(mem_bls_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected pins {ack, cs_n, oe_n, we_n, bls_n[1], bls_n[0], dq_oe} in clock k after acceptance.
    function automatic logic [6:0] exp_pins(input bit wr, input bit prot, input bit both,
                                            input logic [1:0] be, input int d, input int l,
                                            input int k);
        int  w;
        bit  wl;
        if (wr && prot) return (k == 0) ? 7'b1111110 : 7'b0111110;
        if (!wr) begin
            if (k <= l) return {1'b0, 1'b0, 1'b0, 1'b1, both ? 2'b00 : 2'b11, 1'b0};
            return (k == l + 1) ? 7'b1111110 : 7'b0111110;
        end
        w = (l > d) ? l : d;
        if (k <= w + 1) begin
            wl = (k >= d) && (k <= w);
            return {1'b0, 1'b0, 1'b1, !wl, !(wl && be[1]), !(wl && be[0]), 1'b1};
        end
        return (k == w + 2) ? 7'b1111110 : 7'b0111110;
    endfunction

    function automatic int ack_clock(input bit wr, input bit prot, input int d, input int l);
        if (wr && prot) return 0;
        if (!wr) return l + 1;
        return ((l > d) ? l : d) + 2;
    endfunction

    // Starts and ends at a falling edge with the block idle.
    task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input bit both, input bit ext, input bit prot,
                       input int d, input int lr, input int lw, input int le, input bit perturb);
        int          l, last;
        logic [15:0] base;
        string       tag;
        l    = ext ? le : (wr ? lw : lr);
        last = ack_clock(wr, prot, d, l);
        base = 16'($urandom);
        tag  = wr ? (prot ? "R9" : (ext ? "R8/R6/R7" : "R6/R7")) : (ext ? "R8/R2" : (both ? "R5/R2" : "R4/R2"));
        rd_strobe_low = both; ext_wait_sel = ext; wr_protect = prot;
        wait_wen = CW'(d); wait_rd = CW'(lr); wait_wr = CW'(lw); wait_ext = CW'(le);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(posedge clk);
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            mem_dq_i = base ^ 16'(k);
            if (perturb && k == 0) begin
                // R10: reprogram everything while the cycle runs
                rd_strobe_low = !both; ext_wait_sel = !ext; wr_protect = !prot;
                wait_wen = CW'($urandom_range(0, 7)); wait_rd = CW'($urandom_range(0, 7));
                wait_wr = CW'($urandom_range(0, 7)); wait_ext = CW'($urandom_range(0, 7));
            end
            chk(perturb ? {tag, "/R10"} : tag,
                {mem_bls_n, 3'b0, req_ack, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe},
                {mem_bls_n, 3'b0, exp_pins(wr, prot, both, be, d, l, k)});
            if (!mem_cs_n) chk("R11 addr", 32'(mem_addr), 32'(a));
            if (wr && !prot && k <= last - 1) chk("R7 wdata", 32'(mem_dq_o), 32'(wd));
            if (k == last) req_valid = 1'b0;
        end
        if (wr && prot) exp_err = 1'b1;
        chk("R9 flag", 32'(prot_err), 32'(exp_err));
        if (!wr) chk("R3 rdata", 32'(rsp_rdata), 32'(base ^ 16'(l)));
        @(negedge clk);
        chk("R2 idle", {25'b0, req_ack, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe},
            32'b0111110);
        if (!wr) chk("R3 hold", 32'(rsp_rdata), 32'(base ^ 16'(l)));
    endtask

    initial begin
        void'($urandom(32'd4711));
        #(CLK_PERIOD * 2.3);
        // R1: reset state
        chk("R1", {25'b0, req_ack, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe}, 32'b0111110);
        chk("R1 err", 32'(prot_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after", {25'b0, req_ack, mem_cs_n, mem_oe_n, mem_we_n, mem_bls_n, mem_dq_oe}, 32'b0111110);

        // Directed corners
        txn(0, 20'h00010, 2'b11, 16'h0, 0, 0, 0, 0, 3, 2, 5, 0);   // R4 strobes high
        txn(0, 20'h00012, 2'b11, 16'h0, 1, 0, 0, 0, 0, 2, 5, 0);   // R5 with L=0
        txn(1, 20'h00020, 2'b01, 16'hA55A, 0, 0, 0, 2, 1, 4, 5, 0); // R6 L>D, low lane
        txn(1, 20'h00022, 2'b10, 16'h1234, 1, 0, 0, 5, 1, 2, 5, 0); // R6 D>L, high lane, R7
        txn(1, 20'h00024, 2'b11, 16'hBEEF, 0, 0, 0, 0, 1, 0, 5, 0); // R6 D=0, L=0
        txn(0, 20'h00030, 2'b11, 16'h0, 0, 1, 0, 0, 1, 1, 6, 0);   // R8 read
        txn(1, 20'h00032, 2'b11, 16'hCAFE, 0, 1, 0, 1, 1, 1, 6, 0); // R8 write
        txn(1, 20'h00040, 2'b11, 16'hDEAD, 1, 0, 1, 1, 2, 2, 2, 0); // R9 blocked
        txn(0, 20'h00042, 2'b11, 16'h0, 0, 0, 1, 0, 2, 2, 2, 0);   // R9 read unaffected
        txn(0, 20'h00044, 2'b11, 16'h0, 1, 0, 0, 0, 4, 1, 1, 1);   // R10 read
        txn(1, 20'h00046, 2'b10, 16'h7777, 0, 0, 0, 3, 2, 1, 1, 1); // R10 write

        // Constrained random mix
        for (int n = 0; n < 200; n++) begin
            txn(bit'($urandom_range(0, 1)), AW'($urandom), 2'($urandom_range(1, 3)),
                16'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                $urandom_range(0, 7) == 0, $urandom_range(0, 6), $urandom_range(0, 6),
                $urandom_range(0, 6), $urandom_range(0, 9), bit'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule